// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs one external memory transfer at a time on an 8-bit bus whose low address byte and data byte share a single set of wires. A core-side request carries a 16-bit address, a write flag, a code/data space select, write data and a per-transfer slow-timing select. The block turns this request into a fixed sequence of phases: address setup, an address strobe pulse, release of the shared port, an optional write-data setup, a data strobe and a hold phase. It returns the read byte with a one-cycle completion pulse.

The upper address byte has its own dedicated output. The shared byte has separate output, input and output-enable signals, so the pad ring or an external bus model can resolve direction. Every phase is a whole number of internal clock cycles set by parameters. The slow-timing mode lengthens only the data strobe.

Top module: `xbus_seq`

## Requirements
- R1: In reset and while idle, as_n, ds_n, dm_n and rw_n are all 1, ad_oe is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_ready and req_valid are both 1. From the next cycle, addr_hi holds req_addr[15:8] unchanged until the transfer ends. During the address strobe, ad_oe is 1 and ad_out carries req_addr[7:0].
- R3: Each transfer gives exactly one as_n low pulse of AS_LOW_CYC cycles (default 1), and as_n and ds_n are never low in the same cycle.
- R4: After as_n rises, the shared port is released (ad_oe 0) for one cycle. On a read, ds_n falls 1 cycle after as_n rises. On a write, it falls 2 cycles after.
- R5: ds_n stays low for RD_DS_CYC cycles on a read (default 3) and WR_DS_CYC cycles on a write (default 2). EXT_CYC cycles (default 1) are added when ext_timing was 1 at acceptance.
- R6: rsp_done is high for exactly one cycle, one cycle after ds_n rises. On a read, rsp_rdata then holds the value of ad_in in the last ds_n-low cycle.
- R7: On a write, ad_oe is 1 with ad_out equal to req_wdata in the cycle before ds_n falls, throughout ds_n low, and in the cycle after ds_n rises.
- R8: rw_n is 0 for a write and 1 for a read. dm_n is 0 for the data space (req_data_space=1) and 1 for code. Both are valid from the cycle after acceptance until the cycle after ds_n rises.
- R9: req_ready is 0 for the whole transfer, and a request presented while busy has no effect. as_n falls at least 2 cycles after the previous ds_n rise.
- R10: ad_oe is never 1 while ds_n is 0 on a read, so the block and the memory never drive the shared port together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock (input clock divided by two) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_space | input | 1 | 1 = data memory, 0 = code memory |
| req_wdata | input | 8 | Write byte |
| ext_timing | input | 1 | Lengthen data strobe for this transfer |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte |
| addr_hi | output | 8 | Dedicated upper address byte |
| ad_out | output | 8 | Shared port output value |
| ad_in | input | 8 | Shared port input value |
| ad_oe | output | 1 | Shared port output enable |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| dm_n | output | 1 | Data memory select, active low |

## Verification
A wrong phase state or counter value shows up at the strobes within one cycle. It appears as a misplaced edge, a wrong pulse width, or the shared port enabled while the memory drives it, and the bus monitor measures all of these to the cycle. A stale request latch shows up as a wrong address at the address strobe, or as a wrong byte stored or returned in the same transfer. The memory model keeps the contents of both spaces apart, so an error in the space select or write path shows up on the next read of that location.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ASL   = 3'd2,
    ST_FLOAT = 3'd3,
    ST_WSET  = 3'd4,
    ST_DSL   = 3'd5,
    ST_HOLD  = 3'd6
  } xbus_state_e;

  typedef struct packed {
    logic write;
    logic data_sp;
    logic ext;
  } xbus_kind_t;

endpackage

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 req_data_space,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 ext_timing,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    wdata_q,
  output xbus_pkg::xbus_kind_t kind_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= '0;
    end else if (accept) begin
      addr_q          <= req_addr;
      wdata_q         <= req_wdata;
      kind_q.write    <= req_write;
      kind_q.data_sp  <= req_data_space;
      kind_q.ext      <= ext_timing;
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AS_LOW_CYC = 1,
  parameter int RD_DS_CYC  = 3,
  parameter int WR_DS_CYC  = 2,
  parameter int EXT_CYC    = 1,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             is_write,
  input  logic             is_ext,
  input  logic             cnt_zero,
  output xbus_state_e      state_q,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept
);

  localparam logic [CNT_W-1:0] AS_LOAD = CNT_W'(AS_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_DS_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_DS_CYC - 1);

  xbus_state_e      state_d;
  logic [CNT_W-1:0] ds_load;
  logic [CNT_W-1:0] ds_base;

  assign ds_base = is_write ? WR_LOAD : RD_LOAD;

  generate
    if (EXT_CYC > 0) begin : g_ext
      localparam logic [CNT_W-1:0] EXT_ADD = CNT_W'(EXT_CYC);
      assign ds_load = is_ext ? (ds_base + EXT_ADD) : ds_base;
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = is_ext;
      assign ds_load    = ds_base;
    end
  endgenerate

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d  = ST_ASL;
        cnt_load = 1'b1;
        cnt_val  = AS_LOAD;
      end
      ST_ASL:   if (cnt_zero) state_d = ST_FLOAT;
      ST_FLOAT: begin
        if (is_write) begin
          state_d = ST_WSET;
        end else begin
          state_d  = ST_DSL;
          cnt_load = 1'b1;
          cnt_val  = ds_load;
        end
      end
      ST_WSET: begin
        state_d  = ST_DSL;
        cnt_load = 1'b1;
        cnt_val  = ds_load;
      end
      ST_DSL:   if (cnt_zero) state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  xbus_state_e              state_q,
  input  logic                     cnt_zero,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  input  xbus_kind_t               kind_q,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     as_n,
  output logic                     ds_n,
  output logic                     rw_n,
  output logic                     dm_n,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata
);

  logic busy;
  logic addr_phase;
  logic wdata_phase;
  logic capture_en;
  logic done_d;

  assign busy        = (state_q != ST_IDLE);
  assign addr_phase  = (state_q == ST_SETUP) || (state_q == ST_ASL);
  assign wdata_phase = kind_q.write &&
                       ((state_q == ST_WSET) || (state_q == ST_DSL) || (state_q == ST_HOLD));

  always_comb begin
    addr_hi = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
    ad_oe   = addr_phase || wdata_phase;
    if (addr_phase)       ad_out = addr_q[DATA_W-1:0];
    else if (wdata_phase) ad_out = wdata_q;
    else                  ad_out = '0;
    as_n = !(state_q == ST_ASL);
    ds_n = !(state_q == ST_DSL);
    rw_n = busy ? !kind_q.write   : 1'b1;
    dm_n = busy ? !kind_q.data_sp : 1'b1;
  end

  assign capture_en = (state_q == ST_DSL) && cnt_zero && !kind_q.write;
  assign done_d     = (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rsp_rdata <= '0;
    else if (capture_en) rsp_rdata <= ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_done <= 1'b0;
    else        rsp_done <= done_d;
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int AS_LOW_CYC = 1,
  parameter int RD_DS_CYC  = 3,
  parameter int WR_DS_CYC  = 2,
  parameter int EXT_CYC    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_data_space,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ext_timing,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic                     as_n,
  output logic                     ds_n,
  output logic                     rw_n,
  output logic                     dm_n
);
  import xbus_pkg::*;

  localparam int DS_MAX  = ((RD_DS_CYC > WR_DS_CYC) ? RD_DS_CYC : WR_DS_CYC) + EXT_CYC;
  localparam int LEN_MAX = (DS_MAX > AS_LOW_CYC) ? DS_MAX : AS_LOW_CYC;
  localparam int CNT_W   = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

  xbus_state_e      state_q;
  xbus_kind_t       kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic             accept;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  assign req_ready = (state_q == ST_IDLE);

  xbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .req_addr       (req_addr),
    .req_write      (req_write),
    .req_data_space (req_data_space),
    .req_wdata      (req_wdata),
    .ext_timing     (ext_timing),
    .addr_q         (addr_q),
    .wdata_q        (wdata_q),
    .kind_q         (kind_q)
  );

  xbus_ctrl #(
    .AS_LOW_CYC (AS_LOW_CYC),
    .RD_DS_CYC  (RD_DS_CYC),
    .WR_DS_CYC  (WR_DS_CYC),
    .EXT_CYC    (EXT_CYC),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .is_write  (kind_q.write),
    .is_ext    (kind_q.ext),
    .cnt_zero  (cnt_zero),
    .state_q   (state_q),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .accept    (accept)
  );

  xbus_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  xbus_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cnt_zero  (cnt_zero),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .kind_q    (kind_q),
    .ad_in     (ad_in),
    .addr_hi   (addr_hi),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rw_n      (rw_n),
    .dm_n      (dm_n),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     rsp_done,
  input logic [ADDR_W-DATA_W-1:0] addr_hi,
  input logic [DATA_W-1:0]        ad_out,
  input logic                     ad_oe,
  input logic                     as_n,
  input logic                     ds_n,
  input logic                     rw_n,
  input logic                     dm_n
);

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (as_n && ds_n && dm_n && rw_n && !ad_oe));

  a_r2_addr_driven_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> ad_oe);

  a_r2_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(addr_hi));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n));

  a_r4_float_before_read_ds: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && rw_n) |-> ($past(!ad_oe) && $past(as_n)));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r6_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_n) |=> rsp_done);

  a_r7_wdata_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && !rw_n) |-> ($past(ad_oe) && ad_oe && $stable(ad_out)));

  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_n) && !rw_n) |-> (ad_oe && $stable(ad_out)));

  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_n) |-> ($stable(rw_n) && $stable(dm_n)));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && rw_n) |-> !ad_oe);

endmodule

bind xbus_seq xbus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .addr_hi   (addr_hi),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .as_n      (as_n),
  .ds_n      (ds_n),
  .rw_n      (rw_n),
  .dm_n      (dm_n)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;

  localparam int AS_LOW = 1;
  localparam int RD_DS  = 3;
  localparam int WR_DS  = 2;
  localparam int EXT    = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        req_write;
  logic        req_data_space;
  logic [7:0]  req_wdata;
  logic        ext_timing;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [7:0]  addr_hi;
  logic [7:0]  ad_out;
  logic [7:0]  ad_in;
  logic        ad_oe;
  logic        as_n, ds_n, rw_n, dm_n;

  always #2.5 clk = ~clk;

  xbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_data_space(req_data_space),
    .req_wdata(req_wdata), .ext_timing(ext_timing), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .addr_hi(addr_hi), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model: key = {space, low address byte}
  logic [7:0] mem     [0:511];
  logic [7:0] ref_mem [0:511];
  logic [8:0] lat_key;

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    lat_key = '0;
  end

  assign ad_in = (!ds_n && rw_n) ? mem[lat_key] : 8'h00;

  // expectations for the transfer in flight
  logic        exp_wr, exp_ext, exp_dm_n;
  logic [15:0] exp_addr;
  logic [7:0]  exp_wd;

  // bus monitor, sampled at the falling edge
  int   cyc = 0;
  int   t_asrise = -100, t_dsrise = -100, t_dsfall = -100;
  int   as_w = 0, ds_w = 0, as_pulses = 0;
  logic p_as = 1'b1, p_ds = 1'b1, p_oe = 1'b0, p_rw = 1'b1, p_dm = 1'b1, p_done = 1'b0;
  logic [7:0] p_ad = '0, p_hi = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!ds_n && rw_n)
        chk(!ad_oe, "R10 contention", int'(ad_oe), 0);
      if (!as_n) as_w++;
      if (!ds_n) ds_w++;
      if (p_as && !as_n) begin
        as_pulses++;
        chk(cyc - t_dsrise >= 2, "R9 as gap", cyc - t_dsrise, 2);
      end
      if (!p_as && as_n) begin
        t_asrise = cyc;
        chk(as_w == AS_LOW, "R3 as width", as_w, AS_LOW);
        as_w = 0;
        chk(p_oe && {p_hi, p_ad} == exp_addr, "R2 address at strobe",
            int'({p_hi, p_ad}), int'(exp_addr));
        chk(p_rw == !exp_wr && p_dm == exp_dm_n, "R8 rw/dm at strobe",
            int'({p_rw, p_dm}), int'({!exp_wr, exp_dm_n}));
        chk(!ad_oe, "R4 port released", int'(ad_oe), 0);
        lat_key = {!p_dm, p_ad};
      end
      if (p_ds && !ds_n) begin
        t_dsfall = cyc;
        chk(cyc - t_asrise == (exp_wr ? 2 : 1), "R4 as-to-ds delay",
            cyc - t_asrise, exp_wr ? 2 : 1);
        if (exp_wr)
          chk(p_oe && p_ad == exp_wd, "R7 write setup", int'(p_ad), int'(exp_wd));
      end
      if (!p_ds && ds_n) begin
        t_dsrise = cyc;
        chk(ds_w == (exp_wr ? WR_DS : RD_DS) + (exp_ext ? EXT : 0), "R5 ds width",
            ds_w, (exp_wr ? WR_DS : RD_DS) + (exp_ext ? EXT : 0));
        ds_w = 0;
        chk(rw_n == p_rw && dm_n == p_dm, "R8 rw/dm hold",
            int'({rw_n, dm_n}), int'({p_rw, p_dm}));
        if (exp_wr) begin
          chk(ad_oe && ad_out == exp_wd, "R7 write hold", int'(ad_out), int'(exp_wd));
          mem[lat_key] = p_ad;
        end
      end
      if (rsp_done) begin
        chk(!p_done, "R6 done single cycle", int'(p_done), 0);
        chk(cyc == t_dsrise + 1, "R6 done timing", cyc - t_dsrise, 1);
      end
    end
    p_as = as_n; p_ds = ds_n; p_oe = ad_oe; p_rw = rw_n; p_dm = dm_n;
    p_ad = ad_out; p_hi = addr_hi; p_done = rsp_done;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rsp_done) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic xfer(input bit wr, input logic [15:0] a, input bit sp,
                      input bit ext, input logic [7:0] wd);
    bit got;
    exp_wr = wr; exp_ext = ext; exp_addr = a; exp_dm_n = !sp; exp_wd = wd;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data_space = sp;
    req_wdata = wd; ext_timing = ext;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", int'(req_ready), 0);
    chk(addr_hi == a[15:8], "R2 high byte", int'(addr_hi), int'(a[15:8]));
    wait_done(got);
    chk(got, "R6 done seen", int'(got), 1);
    if (wr) ref_mem[{sp, a[7:0]}] = wd;
    else chk(rsp_rdata == ref_mem[{sp, a[7:0]}], "R6 read data",
             int'(rsp_rdata), int'(ref_mem[{sp, a[7:0]}]));
  endtask

  task automatic t_reset_state();
    chk(as_n && ds_n && dm_n && rw_n, "R1 strobes in reset",
        int'({as_n, ds_n, dm_n, rw_n}), 15);
    chk(!ad_oe && req_ready, "R1 port/ready in reset", int'({ad_oe, req_ready}), 1);
  endtask

  task automatic t_idle_state();
    chk(as_n && ds_n && dm_n && rw_n && !ad_oe && req_ready, "R1 idle pins",
        int'({as_n, ds_n, dm_n, rw_n, ad_oe, req_ready}), 61);
  endtask

  task automatic t_busy_ignored();
    int   pulses0;
    bit   got;
    exp_wr = 1'b0; exp_ext = 1'b0; exp_addr = 16'h1234; exp_dm_n = 1'b1; exp_wd = 8'h00;
    pulses0 = as_pulses;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h1234; req_data_space = 1'b0;
    ext_timing = 1'b0;
    @(negedge clk);
    // present a conflicting write while busy
    req_write = 1'b1; req_addr = 16'h0077; req_data_space = 1'b1; req_wdata = 8'hEE;
    @(negedge clk);
    chk(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(got);
    chk(got && rsp_rdata == ref_mem[{1'b0, 8'h34}], "R9 busy read data",
        int'(rsp_rdata), int'(ref_mem[{1'b0, 8'h34}]));
    repeat (3) @(negedge clk);
    chk(as_pulses - pulses0 == 1, "R9 one strobe only", as_pulses - pulses0, 1);
    chk(mem[{1'b1, 8'h77}] == ref_mem[{1'b1, 8'h77}], "R9 ignored write",
        int'(mem[{1'b1, 8'h77}]), int'(ref_mem[{1'b1, 8'h77}]));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_data_space = 1'b0; req_wdata = '0; ext_timing = 1'b0;
    exp_wr = 1'b0; exp_ext = 1'b0; exp_addr = '0; exp_dm_n = 1'b1; exp_wd = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_idle_state();

    xfer(1'b0, 16'hA512, 1'b0, 1'b0, 8'h00);   // code read
    xfer(1'b0, 16'h3C12, 1'b1, 1'b0, 8'h00);   // data read, same low byte
    xfer(1'b1, 16'h4480, 1'b1, 1'b0, 8'h5A);   // data write
    xfer(1'b0, 16'h4480, 1'b1, 1'b0, 8'h00);   // read back
    xfer(1'b0, 16'h4480, 1'b0, 1'b0, 8'h00);   // code space untouched
    xfer(1'b0, 16'h00FF, 1'b0, 1'b1, 8'h00);   // slow read
    xfer(1'b1, 16'hFF01, 1'b0, 1'b1, 8'hC3);   // slow write
    xfer(1'b0, 16'hFF01, 1'b0, 1'b1, 8'h00);
    // back to back, no idle gap between requests
    xfer(1'b1, 16'h0100, 1'b1, 1'b0, 8'h01);
    xfer(1'b1, 16'h0101, 1'b1, 1'b0, 8'h02);
    xfer(1'b0, 16'h0100, 1'b1, 1'b0, 8'h00);
    t_busy_ignored();
    @(negedge clk);
    t_idle_state();
    finish_run();
  end

endmodule